// File: doc/BRIEF.md
# Privilege Access Permission Checker

This block decides whether a single access request may proceed, given the privilege level the processor is running at (0 to 3, larger meaning more privileged) and whether it is in secure or non-secure state. A request is either a memory access or a system-register access. For a memory access the request carries four permission bits for the target region and a flag telling whether the physical address lies in the secure space. For a register access it carries the lowest privilege level allowed to touch that register and a flag marking the register as reachable only from secure state.

The decision is combinational: `grant` and a two-bit `fault_cause` are valid in the same cycle as the request. A registered copy follows one cycle later as `fault_strobe` with `fault_code`, so a downstream exception unit can take the fault from a flop. Table walking, the register storage and exception entry are handled elsewhere.

Top module: `priv_access_checker`

## Requirements
- R1: A memory request at level 0 is checked against the unprivileged bits: `mem_perm[2]` permits reads and `mem_perm[3]` permits writes; a missing permission gives cause 1.
- R2: A memory request at level 1, 2 or 3 is checked against the privileged bits: `mem_perm[0]` permits reads and `mem_perm[1]` permits writes; the unprivileged bits have no effect there; a missing permission gives cause 1.
- R3: A register request (`req_is_reg` = 1) from a level below `reg_min_level` gives cause 2.
- R4: A register request from a level at or above `reg_min_level` (and not level 0) is granted when no security violation applies, so a level-2 access to a level-1 register passes.
- R5: A register request from level 0 always faults with cause 2 when no security violation applies, whatever `reg_min_level` holds.
- R6: In non-secure state (`cur_secure` = 0) a register with `reg_secure_only` = 1 gives cause 3; in secure state it is subject only to the level rule.
- R7: In non-secure state a memory request with `mem_addr_secure` = 1 gives cause 3; in secure state secure addresses pass to the permission check.
- R8: Cause encoding is 0 none, 1 memory permission, 2 register level, 3 security; when a security violation and another violation coincide, cause 3 is reported.
- R9: `grant` is 1 exactly when `req_valid` is 1 and the cause is 0; with `req_valid` = 0 both `grant` and `fault_cause` are 0.
- R10: `fault_strobe` is 1 in the cycle after a valid request with a nonzero cause, with `fault_code` equal to that cause; it is 0 after a granted or idle cycle, and reset forces both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_reg | input | 1 | 1 = register access, 0 = memory access |
| cur_level | input | 2 | Current privilege level |
| cur_secure | input | 1 | 1 = secure state |
| mem_write | input | 1 | 1 = write, 0 = read (memory only) |
| mem_perm | input | 4 | [0] priv read, [1] priv write, [2] unpriv read, [3] unpriv write |
| mem_addr_secure | input | 1 | Target address lies in secure space |
| reg_min_level | input | 2 | Lowest level that owns the register |
| reg_secure_only | input | 1 | Register reachable only from secure state |
| grant | output | 1 | Request allowed (combinational) |
| fault_cause | output | 2 | Cause code (combinational) |
| fault_strobe | output | 1 | Registered fault pulse |
| fault_code | output | 2 | Registered cause matching the strobe |

## Verification
The hardest case to reach from the ports is two violations at once, a security breach together with a missing permission or a too-low level, where only priority ordering decides the code. Random stimulus draws security state and flags with equal odds so such overlaps arise often, and directed requests place a secure-address write without permission and a level-0 access to a secure-only register in non-secure state. A reset pulse is applied directly after a faulting request to show the strobe clears before its normal drop.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int LVL_W  = 2;
  localparam int PERM_W = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PERM  = 2'd1,
    CAUSE_LEVEL = 2'd2,
    CAUSE_SEC   = 2'd3
  } cause_e;

  // bit 0 is the least significant member (last in the list)
  typedef struct packed {
    logic user_wr;
    logic user_rd;
    logic priv_wr;
    logic priv_rd;
  } perm_t;
endpackage

// File: rtl/mem_perm_check.sv
module mem_perm_check #(
  parameter int LVL_W      = 2,
  parameter int PERM_W     = 4,
  parameter int USER_LEVEL = 0
) (
  input  logic [LVL_W-1:0]  cur_level,
  input  logic              is_write,
  input  logic [PERM_W-1:0] perm,
  output logic              perm_fault
);
  import pac_pkg::*;

  localparam logic [LVL_W-1:0] USER_LVL = LVL_W'(USER_LEVEL);

  perm_t perm_s;
  logic  from_user;
  logic  may_read;
  logic  may_write;

  always_comb begin
    perm_s    = perm_t'(perm);
    from_user = (cur_level == USER_LVL);
    may_read  = from_user ? perm_s.user_rd : perm_s.priv_rd;
    may_write = from_user ? perm_s.user_wr : perm_s.priv_wr;
    perm_fault = is_write ? !may_write : !may_read;
  end
endmodule

// File: rtl/reg_level_check.sv
module reg_level_check #(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] cur_level,
  input  logic [LVL_W-1:0] min_level,
  output logic             level_fault
);
  localparam logic [LVL_W-1:0] NO_OWNER_LVL = '0;

  logic below_owner;
  logic unowned_level;

  always_comb begin
    below_owner   = (cur_level < min_level);
    unowned_level = (cur_level == NO_OWNER_LVL);
    level_fault   = below_owner || unowned_level;
  end
endmodule

// File: rtl/sec_gate.sv
module sec_gate (
  input  logic is_reg,
  input  logic cur_secure,
  input  logic addr_secure,
  input  logic reg_secure_only,
  output logic sec_fault
);
  logic target_secure;

  always_comb begin
    target_secure = is_reg ? reg_secure_only : addr_secure;
    sec_fault     = !cur_secure && target_secure;
  end
endmodule

// File: rtl/fault_reg.sv
module fault_reg #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CODE_W-1:0] cause_in,
  output logic              strobe,
  output logic [CODE_W-1:0] code_q
);
  logic              strobe_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic              upd_en;

  always_comb begin
    upd_en     = 1'b1;
    strobe_nxt = valid && (cause_in != '0);
    code_nxt   = strobe_nxt ? cause_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      code_q <= '0;
    end else if (upd_en) begin
      strobe <= strobe_nxt;
      code_q <= code_nxt;
    end
  end

  p_strobe_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cause_in != '0) |=> (strobe && code_q == $past(cause_in)));

  p_quiet_after_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || cause_in == '0) |=> (!strobe && code_q == '0));
endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker #(
  parameter int LVL_W  = pac_pkg::LVL_W,
  parameter int PERM_W = pac_pkg::PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_reg,
  input  logic [LVL_W-1:0]  cur_level,
  input  logic              cur_secure,
  input  logic              mem_write,
  input  logic [PERM_W-1:0] mem_perm,
  input  logic              mem_addr_secure,
  input  logic [LVL_W-1:0]  reg_min_level,
  input  logic              reg_secure_only,
  output logic              grant,
  output logic [1:0]        fault_cause,
  output logic              fault_strobe,
  output logic [1:0]        fault_code
);
  import pac_pkg::*;

  logic   perm_fault;
  logic   level_fault;
  logic   sec_fault;
  cause_e cause;

  mem_perm_check #(.LVL_W(LVL_W), .PERM_W(PERM_W), .USER_LEVEL(0)) u_mem (
    .cur_level (cur_level),
    .is_write  (mem_write),
    .perm      (mem_perm),
    .perm_fault(perm_fault)
  );

  reg_level_check #(.LVL_W(LVL_W)) u_lvl (
    .cur_level  (cur_level),
    .min_level  (reg_min_level),
    .level_fault(level_fault)
  );

  sec_gate u_sec (
    .is_reg         (req_is_reg),
    .cur_secure     (cur_secure),
    .addr_secure    (mem_addr_secure),
    .reg_secure_only(reg_secure_only),
    .sec_fault      (sec_fault)
  );

  // security first, then the check that belongs to the access kind
  always_comb begin
    cause = CAUSE_NONE;
    if (req_valid) begin
      if (sec_fault)                      cause = CAUSE_SEC;
      else if (req_is_reg && level_fault) cause = CAUSE_LEVEL;
      else if (!req_is_reg && perm_fault) cause = CAUSE_PERM;
    end
    fault_cause = cause;
    grant       = req_valid && (cause == CAUSE_NONE);
  end

  fault_reg #(.CODE_W(2)) u_freg (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .cause_in(fault_cause),
    .strobe  (fault_strobe),
    .code_q  (fault_code)
  );

  p_user_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_reg && cur_level == '0 && !mem_write && !mem_perm[2]
     && (cur_secure || !mem_addr_secure)) |-> fault_cause == 2'd1);

  p_priv_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_reg && cur_level != '0 && mem_write && mem_perm[1]
     && (cur_secure || !mem_addr_secure)) |-> grant);

  p_below_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_reg && cur_level < reg_min_level
     && (cur_secure || !reg_secure_only)) |-> fault_cause == 2'd2);

  p_higher_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_reg && cur_level >= reg_min_level && cur_level != '0
     && (cur_secure || !reg_secure_only)) |-> grant);

  p_level0_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_reg && cur_level == '0 && cur_secure) |-> fault_cause == 2'd2);

  p_ns_secreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_reg && !cur_secure && reg_secure_only) |-> fault_cause == 2'd3);

  p_ns_secaddr_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_reg && !cur_secure && mem_addr_secure) |-> fault_cause == 2'd3);

  p_grant_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (req_valid && fault_cause == 2'd0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && fault_cause == 2'd0));
endmodule

// File: tb/priv_access_checker_bench.sv
`timescale 1ns/1ps
module priv_access_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_is_reg = 1'b0;
  logic [1:0] cur_level = 2'd0;
  logic       cur_secure = 1'b0;
  logic       mem_write = 1'b0;
  logic [3:0] mem_perm = 4'd0;
  logic       mem_addr_secure = 1'b0;
  logic [1:0] reg_min_level = 2'd0;
  logic       reg_secure_only = 1'b0;
  logic       grant;
  logic [1:0] fault_cause;
  logic       fault_strobe;
  logic [1:0] fault_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  priv_access_checker u_priv_access_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_reg(req_is_reg),
    .cur_level(cur_level), .cur_secure(cur_secure), .mem_write(mem_write),
    .mem_perm(mem_perm), .mem_addr_secure(mem_addr_secure),
    .reg_min_level(reg_min_level), .reg_secure_only(reg_secure_only),
    .grant(grant), .fault_cause(fault_cause), .fault_strobe(fault_strobe),
    .fault_code(fault_code)
  );

  function automatic logic [1:0] model_cause();
    logic sec;
    logic ok;
    if (!req_valid) return 2'd0;
    sec = !cur_secure && (req_is_reg ? reg_secure_only : mem_addr_secure);
    if (sec) return 2'd3;                                   // R6 R7 R8
    if (req_is_reg) begin
      if (cur_level == 2'd0 || cur_level < reg_min_level) return 2'd2; // R3 R5
      return 2'd0;                                          // R4
    end
    if (cur_level == 2'd0) ok = mem_write ? mem_perm[3] : mem_perm[2]; // R1
    else                   ok = mem_write ? mem_perm[1] : mem_perm[0]; // R2
    return ok ? 2'd0 : 2'd1;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational, then registered after the edge
  task automatic run(string req);
    logic [1:0] ec;
    #1;
    ec = model_cause();
    check({req, " cause"}, {2'b0, fault_cause}, {2'b0, ec});
    check("R9 grant", {3'b0, grant}, {3'b0, (req_valid && ec == 2'd0)});
    @(posedge clk); #1;
    check("R10 strobe", {3'b0, fault_strobe}, {3'b0, (ec != 2'd0)});
    check("R10 code", {2'b0, fault_code}, {2'b0, ec});
    @(negedge clk);
  endtask

  task automatic set_mem(logic [1:0] lv, logic sec, logic wr, logic [3:0] p, logic asec);
    req_valid = 1; req_is_reg = 0; cur_level = lv; cur_secure = sec;
    mem_write = wr; mem_perm = p; mem_addr_secure = asec;
    reg_min_level = 2'd0; reg_secure_only = 0;
  endtask

  task automatic set_reg(logic [1:0] lv, logic sec, logic [1:0] ml, logic so);
    req_valid = 1; req_is_reg = 1; cur_level = lv; cur_secure = sec;
    mem_write = 0; mem_perm = 4'd0; mem_addr_secure = 0;
    reg_min_level = ml; reg_secure_only = so;
  endtask

  initial begin
    void'($urandom(32'd7741));
    #3;
    check("R10 reset strobe", {3'b0, fault_strobe}, 4'd0);
    check("R10 reset code", {2'b0, fault_code}, 4'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    req_valid = 0; run("R9 idle");
    set_mem(2'd0, 1, 0, 4'b0100, 0); run("R1 user read ok");
    set_mem(2'd0, 1, 0, 4'b0011, 0); run("R1 user read denied");
    set_mem(2'd0, 0, 1, 4'b1000, 0); run("R1 user write ok");
    set_mem(2'd1, 1, 0, 4'b0001, 1); run("R2 priv read secure addr");
    set_mem(2'd3, 1, 1, 4'b1100, 0); run("R2 user bits ignored");
    set_mem(2'd2, 0, 1, 4'b0010, 0); run("R2 priv write ok");
    set_reg(2'd1, 1, 2'd2, 0); run("R3 below owner");
    set_reg(2'd2, 0, 2'd1, 0); run("R4 higher ok");
    set_reg(2'd3, 1, 2'd3, 1); run("R4 equal secure");
    set_reg(2'd0, 1, 2'd0, 0); run("R5 level0 reg");
    set_reg(2'd2, 0, 2'd1, 1); run("R6 ns secure-only");
    set_reg(2'd0, 0, 2'd3, 1); run("R8 sec over level");
    set_mem(2'd1, 0, 1, 4'b0000, 1); run("R7 R8 sec over perm");

    for (int i = 0; i < 400; i++) begin
      req_valid = ($urandom_range(0, 7) != 0);
      req_is_reg = $urandom_range(0, 1);
      cur_level = 2'($urandom_range(0, 3));
      cur_secure = $urandom_range(0, 1);
      mem_write = $urandom_range(0, 1);
      mem_perm = 4'($urandom_range(0, 15));
      mem_addr_secure = $urandom_range(0, 1);
      reg_min_level = 2'($urandom_range(0, 3));
      reg_secure_only = $urandom_range(0, 1);
      run("R8 random");
    end

    set_reg(2'd0, 1, 2'd1, 0);
    @(posedge clk); #1;
    check("R10 strobe before reset", {3'b0, fault_strobe}, 4'd1);
    rst_n = 0; #1;
    check("R10 reset clears strobe", {3'b0, fault_strobe}, 4'd0);
    check("R10 reset clears code", {2'b0, fault_code}, 4'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule